// File: doc/BRIEF.md
# Timing Pattern Output Controller

This block drives a 16-bit parallel pattern onto output pins in step with timer events. Software first loads the next pattern into a buffer register. When the timer compare-match event chosen for a group arrives, the buffered bits are copied into the output register, so the pins change on a known timer edge and do not depend on when the software write happened.

The outputs are split into four 4-bit groups. Each group chooses one of four compare-match strobes as its trigger, and each output bit has its own transfer enable. A small register bus gives read and write access to the buffer, the enable mask and the trigger selection. The bus can also read the output register. The compare-match strobes arrive as single-cycle pulses.

Top module: `tpo_ctrl`

## Requirements
- R1: After reset the output register, the enable mask and the next-data buffer are all zero. The trigger-select register is 0xFF, so every group starts on channel 3.
- R2: Bus address 0 reads and writes the next-data buffer. Address 1 reads and writes the enable mask, with bit n gating output bit n. Address 2 reads and writes the trigger-select register in data bits 7:0, and its upper read bits are zero. Address 3 reads the output register. Read data is combinational from the address.
- R3: The trigger-select register holds one 2-bit field per group: bits 1:0 for group 0 (outputs 3:0), bits 3:2 for group 1 (outputs 7:4), bits 5:4 for group 2 (outputs 11:8) and bits 7:6 for group 3 (outputs 15:12). A field value k selects compare-match strobe k, where bit k of the strobe input is channel k.
- R4: On a clock edge where a group's selected strobe is high, every enabled bit of that group takes its next-data value.
- R5: An output bit whose enable is 0 keeps its value, even when its group is triggered.
- R6: When a bus write to the next-data buffer falls on the same edge as a trigger, the outputs take the old buffer contents, and the buffer then holds the newly written value.
- R7: Groups that share a trigger source all update on the same edge. A strobe that no group selects has no effect on the outputs.
- R8: A group whose selected strobe is low keeps its output bits unchanged.
- R9: A bus write to address 3 has no effect on the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| cmp_stb | input | 4 | Compare-match pulses, one bit per timer channel |
| pat_o | output | 16 | Pattern output register |

## Verification
The assertions assume that the strobes and the bus signals are stable, 2-state values at each rising edge. They also assume that reset is held low from time zero until at least one edge has passed. The bench meets this by driving every input only on the falling edge, starting with all inputs at zero and reset asserted, and by releasing reset only after several cycles. Strobe patterns cover single channels, several channels at once and channels that no group selects. The bench does not need the strobes to be single pulses, because each high cycle is simply treated as a trigger.

// File: rtl/tpo_ctrl.sv
module tpo_ctrl #(
  parameter int GROUPS   = 4,
  parameter int GW       = 4,
  parameter int CHANNELS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_we,
  input  logic [1:0]               bus_addr,
  input  logic [GROUPS*GW-1:0]     bus_wdata,
  output logic [GROUPS*GW-1:0]     bus_rdata,
  input  logic [CHANNELS-1:0]      cmp_stb,
  output logic [GROUPS*GW-1:0]     pat_o
);
  localparam int W    = GROUPS * GW;
  localparam int SW   = $clog2(CHANNELS);
  localparam int SELW = GROUPS * SW;

  logic [W-1:0]    nd_q, en_q, pat_q, load;
  logic [SELW-1:0] sel_q;
  logic [GROUPS-1:0] grp_trig;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [SW-1:0] fsel;
    assign fsel        = sel_q[g*SW +: SW];
    assign grp_trig[g] = cmp_stb[fsel];
    assign load[g*GW +: GW] = {GW{grp_trig[g]}} & en_q[g*GW +: GW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nd_q  <= '0;
      en_q  <= '0;
      sel_q <= '1;
      pat_q <= '0;
    end else begin
      pat_q <= (pat_q & ~load) | (nd_q & load);
      if (bus_we) begin
        case (bus_addr)
          2'd0:    nd_q  <= bus_wdata;
          2'd1:    en_q  <= bus_wdata;
          2'd2:    sel_q <= bus_wdata[SELW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = nd_q;
      2'd1:    bus_rdata = en_q;
      2'd2:    bus_rdata = {{(W-SELW){1'b0}}, sel_q};
      default: bus_rdata = pat_q;
    endcase
  end

  assign pat_o = pat_q;
endmodule

// File: rtl/tpo_ctrl_chk.sv
module tpo_ctrl_chk #(
  parameter int GROUPS   = 4,
  parameter int GW       = 4,
  parameter int CHANNELS = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [1:0]                     bus_addr,
  input logic [GROUPS*GW-1:0]           bus_rdata,
  input logic [CHANNELS-1:0]            cmp_stb,
  input logic [GROUPS*GW-1:0]           pat_o,
  input logic [GROUPS*GW-1:0]           nd_q,
  input logic [GROUPS*GW-1:0]           en_q,
  input logic [GROUPS*$clog2(CHANNELS)-1:0] sel_q
);
  localparam int W    = GROUPS * GW;
  localparam int SW   = $clog2(CHANNELS);
  localparam int SELW = GROUPS * SW;

  logic [W-1:0] lmask;
  always_comb begin
    lmask = '0;
    for (int b = 0; b < W; b++)
      if (en_q[b] && cmp_stb[sel_q[(b/GW)*SW +: SW]]) lmask[b] = 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pat_o == '0 && en_q == '0 && nd_q == '0 && sel_q == '1)); // R1
  AST_SEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 2'd2 |-> bus_rdata == {{(W-SELW){1'b0}}, sel_q}); // R2
  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pat_o ^ $past(nd_q)) & $past(lmask)) == '0); // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pat_o ^ $past(pat_o)) & ~$past(en_q)) == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pat_o ^ $past(pat_o)) & ~$past(lmask)) == '0); // R8
endmodule

bind tpo_ctrl tpo_ctrl_chk #(.GROUPS(GROUPS), .GW(GW), .CHANNELS(CHANNELS)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cmp_stb(cmp_stb), .pat_o(pat_o), .nd_q(nd_q), .en_q(en_q), .sel_q(sel_q)
);

// File: tb/tpo_ctrl_tb_top.sv
module tpo_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  cmp_stb = '0;
  logic [15:0] pat_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  tpo_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_stb(cmp_stb), .pat_o(pat_o));

  // {we, addr, wdata, strobes, expected pat_o after the edge}
  localparam int NV = 20;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'hA5C3, 4'h0, 16'h0000},  // R2 load buffer
    {1'b0, 2'd0, 16'h0000, 4'h8, 16'h0000},  // R5 all disabled
    {1'b1, 2'd1, 16'hFFFF, 4'h0, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 4'h8, 16'hA5C3},  // R4 R7 reset select ch3, all groups
    {1'b1, 2'd2, 16'h001B, 4'h0, 16'hA5C3},  // R3 g3=0 g2=1 g1=2 g0=3
    {1'b1, 2'd0, 16'h1234, 4'h0, 16'hA5C3},
    {1'b0, 2'd0, 16'h0000, 4'h1, 16'h15C3},  // R3 ch0 -> group3
    {1'b0, 2'd0, 16'h0000, 4'h4, 16'h1533},  // R3 R8 ch2 -> group1
    {1'b1, 2'd1, 16'h0F0F, 4'h2, 16'h1233},  // R3 ch1 -> group2, old enable
    {1'b1, 2'd0, 16'hFFFF, 4'h8, 16'h1234},  // R6 old buffer wins
    {1'b0, 2'd0, 16'h0000, 4'hF, 16'h1F3F},  // R5 groups 3,1 disabled
    {1'b1, 2'd2, 16'h0000, 4'h0, 16'h1F3F},
    {1'b0, 2'd0, 16'h0000, 4'hE, 16'h1F3F},  // R7 unselected strobes
    {1'b1, 2'd1, 16'hFFFF, 4'h0, 16'h1F3F},
    {1'b1, 2'd0, 16'h0000, 4'hE, 16'h1F3F},  // R7 unselected strobes
    {1'b0, 2'd0, 16'h0000, 4'h1, 16'h0000},  // R7 shared source
    {1'b1, 2'd1, 16'h0005, 4'h0, 16'h0000},
    {1'b1, 2'd0, 16'hFFFF, 4'h0, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 4'h1, 16'h0005},  // R5 per-bit inside a group
    {1'b1, 2'd3, 16'h0000, 4'h0, 16'h0005}   // R9 write to output ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    bus_we = 1'b0; bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pat", pat_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 nd", 2'd0, 16'h0000);
    rd("R1 en", 2'd1, 16'h0000);
    rd("R1 sel", 2'd2, 16'h00FF);
    rd("R1 out", 2'd3, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      {bus_we, bus_addr, bus_wdata, cmp_stb} = VEC[i][38:16];
      @(negedge clk);
      chk($sformatf("R4 vec%0d", i), pat_o, VEC[i][15:0]);
    end
    bus_we = 1'b0; cmp_stb = '0;
    rd("R2 nd", 2'd0, 16'hFFFF);
    rd("R2 en", 2'd1, 16'h0005);
    rd("R2 sel", 2'd2, 16'h0000);
    rd("R9 out", 2'd3, 16'h0005);
    // R2 upper select bits read as zero
    bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 16'hFF6C;
    @(negedge clk);
    rd("R2 sel upper", 2'd2, 16'h006C);
    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pat again", pat_o, 16'h0000);
    rd("R1 sel again", 2'd2, 16'h00FF);
    rd("R1 en again", 2'd1, 16'h0000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule